// File: doc/BRIEF.md
# Subranging Offset Search and Inverse-Curve Linearizer

This block widens the range of a slow stochastic fine converter and straightens its transfer curve. The fine converter resolves only a narrow input window. The block therefore selects one of eight reference offsets for the sensing element and asks for a fine conversion at each offset. It searches upward from the lowest offset and stops at the first offset where the fine result is not pinned at either end of its scale. The offset index becomes the three upper bits of the 8-bit result. The five lower bits come from a 32-entry table that maps the raw fine code through the inverse of the measured fine transfer curve.

The table is loaded once, while calibration mode is held. During calibration the block also smooths the raw fine codes with a four-sample moving average. Calibration logic outside the block reads this average while it sweeps a known ramp, and it uses the result to build the inverse curve that it writes into the table. At each offset step the analog side shifts the reference node by 128 mV, which covers −384 mV to +512 mV. The offset divider, the buffer and the ramp source are not part of this block.

Top module: `sub_range_lin`

## Requirements
- R1: After reset, `dout` is 0, `dout_vld`, `fine_req` and `off_sel` are 0, `cal_avg` is 0, and each table entry holds its own address (identity mapping).
- R2: A `start` pulse that arrives while the block is idle and `cal_mode` is low sets `off_sel` to 0 and raises `fine_req` for exactly one cycle, in the cycle after `start`.
- R3: A fine response (`fine_vld` high) whose `fine_code` is 0 or 31, arriving while `off_sel` is below 7, raises `off_sel` by one and issues a new one-cycle `fine_req` in the next cycle. Successive requests therefore use offsets 0, 1, 2 and so on.
- R4: The first fine response with a code from 1 to 30 ends the search. In the cycle after that `fine_vld`, `dout_vld` is high for exactly one cycle and `dout` = {`off_sel`[2:0], table[`fine_code`]}, with the offset index in bits 7:5.
- R5: A code of 31 at offset 7 ends the search with `dout` = 255. A code of 0 at offset 7 ends it with `dout` = 0. Both appear with a one-cycle `dout_vld` in the following cycle.
- R6: While `cal_mode` is high, `cal_we` writes `cal_data` into the table entry at `cal_addr` on the clock edge, and later conversions use the new value.
- R7: A `cal_we` pulse while `cal_mode` is low leaves the table unchanged.
- R8: While `cal_mode` is high, each `fine_vld` shifts `fine_code` into a four-deep window. `cal_avg` equals the sum of the window divided by 4 and rounded down, and the window starts as all zeros.
- R9: A `fine_vld` while `cal_mode` is low leaves `cal_avg` unchanged.
- R10: The block ignores `start` while a search is in progress or while `cal_mode` is high.
- R11: While the block waits for a fine response, `off_sel` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one wide-range conversion |
| cal_mode | input | 1 | Calibration mode: enables table writes and averaging, blocks conversions |
| cal_we | input | 1 | Table write enable |
| cal_addr | input | 5 | Table write address (raw fine code) |
| cal_data | input | 5 | Corrected fine code to store |
| off_sel | output | 3 | Selected reference offset index |
| fine_req | output | 1 | One-cycle request for a fine conversion |
| fine_vld | input | 1 | Fine conversion result valid |
| fine_code | input | 5 | Raw fine code |
| cal_avg | output | 5 | Four-sample moving average of raw codes in calibration |
| dout | output | 8 | Corrected wide-range code |
| dout_vld | output | 1 | `dout` is valid (one-cycle pulse) |

## Verification
The assertions assume that the fine converter answers only while a request is outstanding. They assume one `fine_vld` pulse per `fine_req`, arriving at least one cycle after the request, and that `fine_code` is stable during that pulse. The stimulus meets these conditions by construction. A bench model of the analog input returns exactly one response a fixed two cycles after each request, and it computes the code from the offset that is on `off_sel` at that moment. Averaging pulses are sent only while the block is idle, so the assumption on requests is never tested against averaging traffic.

// File: rtl/sub_pkg.sv
// Shared definitions for the subranging linearizer.
// Assumes: offset index and fine code widths fixed for the whole block.
package sub_pkg;
    localparam int OFF_W  = 3;
    localparam int FINE_W = 5;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2
    } srch_st_t;
endpackage

// File: rtl/sub_inv_lut.sv
// Inverse transfer-curve table: one corrected code per raw fine code.
// Assumes: writes are already qualified by calibration mode upstream;
// read is combinational from registered storage.
module sub_inv_lut #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] rd_addr,
    output logic [W-1:0] rd_data
);
    localparam int DEPTH = 1 << W;

    logic [W-1:0] mem [DEPTH];

    // Storage: identity on reset, single-entry write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= W'(i);
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read port.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sub_avg.sv
// Moving average over the last 2**LOG2N accepted samples, divided by shift.
// Assumes: window starts as zeros; result is floor of the mean.
module sub_avg #(
    parameter int W     = 5,
    parameter int LOG2N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] avg
);
    localparam int N     = 1 << LOG2N;
    localparam int SUM_W = W + LOG2N;

    logic [W-1:0]     tap [N];
    logic [SUM_W-1:0] sum;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_tap
            // Window stage g: shifts on each accepted sample.
            always_ff @(posedge clk) begin
                if (!rst_n)  tap[g] <= '0;
                else if (en) tap[g] <= (g == 0) ? din : tap[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    // Window sum.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) sum = sum + SUM_W'(tap[i]);
    end

    // Shift-based divide.
    assign avg = W'(sum >> LOG2N);
endmodule

// File: rtl/sub_search_fsm.sv
// Upward offset search: requests fine conversions from offset 0 until a
// non-saturated code appears, then registers {offset, corrected code}.
// Assumes: one fine_vld per fine_req; lut_q is the table entry for fine_code.
module sub_search_fsm
    import sub_pkg::*;
#(
    parameter int OW = 3,
    parameter int FW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cal_mode,
    input  logic            fine_vld,
    input  logic [FW-1:0]   fine_code,
    input  logic [FW-1:0]   lut_q,
    output logic [OW-1:0]   off_sel,
    output logic            fine_req,
    output logic            waiting,
    output logic [OW+FW-1:0] dout,
    output logic            dout_vld
);
    localparam logic [OW-1:0] OFF_MAX  = '1;
    localparam logic [FW-1:0] FINE_MAX = '1;

    srch_st_t     st;
    logic [OW-1:0] idx;
    logic         sat_lo, sat_hi;

    // Saturation detection on the raw code.
    assign sat_lo = (fine_code == '0);
    assign sat_hi = (fine_code == FINE_MAX);

    // Search sequencer and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            idx      <= '0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= 1'b0;
            case (st)
                S_IDLE: if (start && !cal_mode) begin
                    idx <= '0;
                    st  <= S_REQ;
                end
                S_REQ: st <= S_WAIT;
                S_WAIT: if (fine_vld) begin
                    if (!sat_lo && !sat_hi) begin
                        dout     <= {idx, lut_q};
                        dout_vld <= 1'b1;
                        st       <= S_IDLE;
                    end else if (idx == OFF_MAX) begin
                        dout     <= sat_hi ? '1 : '0;
                        dout_vld <= 1'b1;
                        st       <= S_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= S_REQ;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from state.
    assign fine_req = (st == S_REQ);
    assign waiting  = (st == S_WAIT);
    assign off_sel  = idx;
endmodule

// File: rtl/sub_range_lin.sv
// Top: offset search, inverse-curve table and calibration averager.
// Assumes: table writes and averaging only count while cal_mode is high.
module sub_range_lin
    import sub_pkg::*;
#(
    parameter int OW    = OFF_W,
    parameter int FW    = FINE_W,
    parameter int AVG_L = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cal_mode,
    input  logic            cal_we,
    input  logic [FW-1:0]   cal_addr,
    input  logic [FW-1:0]   cal_data,
    output logic [OW-1:0]   off_sel,
    output logic            fine_req,
    input  logic            fine_vld,
    input  logic [FW-1:0]   fine_code,
    output logic [FW-1:0]   cal_avg,
    output logic [OW+FW-1:0] dout,
    output logic            dout_vld
);
    logic [FW-1:0] lut_q;
    logic          srch_wait;

    // Table, writable only in calibration mode.
    sub_inv_lut #(.W(FW)) i_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cal_mode && cal_we),
        .wr_addr (cal_addr),
        .wr_data (cal_data),
        .rd_addr (fine_code),
        .rd_data (lut_q)
    );

    // Smoothing of raw codes during calibration.
    sub_avg #(.W(FW), .LOG2N(AVG_L)) i_avg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cal_mode && fine_vld),
        .din   (fine_code),
        .avg   (cal_avg)
    );

    // Offset search and result assembly.
    sub_search_fsm #(.OW(OW), .FW(FW)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cal_mode  (cal_mode),
        .fine_vld  (fine_vld),
        .fine_code (fine_code),
        .lut_q     (lut_q),
        .off_sel   (off_sel),
        .fine_req  (fine_req),
        .waiting   (srch_wait),
        .dout      (dout),
        .dout_vld  (dout_vld)
    );
endmodule

// File: rtl/sub_range_lin_chk.sv
// Protocol checker for sub_range_lin, bound to every instance.
module sub_range_lin_chk #(
    parameter int OW = 3,
    parameter int FW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            cal_mode,
    input logic            fine_vld,
    input logic [FW-1:0]   fine_code,
    input logic            fine_req,
    input logic            srch_wait,
    input logic [OW-1:0]   off_sel,
    input logic [OW+FW-1:0] dout,
    input logic            dout_vld
);
    localparam logic [OW-1:0] OMAX = '1;
    localparam logic [FW-1:0] FMAX = '1;

    logic idle;
    logic sat;
    assign idle = !srch_wait && !fine_req;
    assign sat  = (fine_code == '0) || (fine_code == FMAX);

    AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        start && idle && !cal_mode |=> fine_req && off_sel == '0); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fine_req |=> !fine_req); // R2
    AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fine_vld && srch_wait && sat && off_sel != OMAX |=> fine_req && off_sel == $past(off_sel) + 1'b1); // R3
    AST_RESULT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        fine_vld && srch_wait && !sat |=> dout_vld && dout[OW+FW-1:FW] == $past(off_sel)); // R4
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |=> !dout_vld); // R4
    AST_CLAMP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        fine_vld && srch_wait && off_sel == OMAX && fine_code == FMAX |=> dout_vld && dout == '1); // R5
    AST_CLAMP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        fine_vld && srch_wait && off_sel == OMAX && fine_code == '0 |=> dout_vld && dout == '0); // R5
    AST_CAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cal_mode && idle |=> !fine_req); // R10
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        srch_wait && !fine_vld |=> $stable(off_sel)); // R11
endmodule

bind sub_range_lin sub_range_lin_chk #(.OW(OW), .FW(FW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cal_mode  (cal_mode),
    .fine_vld  (fine_vld),
    .fine_code (fine_code),
    .fine_req  (fine_req),
    .srch_wait (srch_wait),
    .off_sel   (off_sel),
    .dout      (dout),
    .dout_vld  (dout_vld)
);

// File: tb/test_sub_range_lin.sv
module test_sub_range_lin;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, cal_mode = 1'b0, cal_we = 1'b0, fine_vld = 1'b0;
    logic [4:0] cal_addr = '0, cal_data = '0, fine_code = '0;
    logic [2:0] off_sel;
    logic       fine_req, dout_vld;
    logic [4:0] cal_avg;
    logic [7:0] dout;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int lut_m [32];

    always #5 clk = ~clk;

    sub_range_lin i_sub_range_lin (
        .clk(clk), .rst_n(rst_n), .start(start), .cal_mode(cal_mode),
        .cal_we(cal_we), .cal_addr(cal_addr), .cal_data(cal_data),
        .off_sel(off_sel), .fine_req(fine_req), .fine_vld(fine_vld),
        .fine_code(fine_code), .cal_avg(cal_avg), .dout(dout), .dout_vld(dout_vld)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int fine_of(int v, int k);
        int c = v - 32 * k;
        if (c < 0) c = 0;
        if (c > 31) c = 31;
        return c;
    endfunction

    // Expected result and request count from the requirements.
    function automatic int model(int v, output int nreq);
        int c;
        for (int k = 0; k < 8; k++) begin
            c = fine_of(v, k);
            nreq = k + 1;
            if (c != 0 && c != 31) return k * 32 + lut_m[c];
        end
        return (c == 31) ? 255 : 0;
    endfunction

    // Full conversion against a modelled input v.
    task automatic convert(int v, string tag);
        int exp_n, exp_d, nreq = 0, guard;
        bit done = 0;
        exp_d = model(v, exp_n);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check({tag, " R2 req after start"}, fine_req, 1);
        check({tag, " R2 first offset"}, off_sel, 0);
        while (!done) begin
            guard = 0;
            while (!fine_req && guard < 20) begin @(negedge clk); guard++; end
            check({tag, " R3 ascending offset"}, off_sel, nreq);
            @(negedge clk);
            @(negedge clk);
            check({tag, " R11 offset held"}, off_sel, nreq);
            fine_vld = 1'b1; fine_code = 5'(fine_of(v, int'(off_sel)));
            @(negedge clk) fine_vld = 1'b0;
            nreq++;
            if (dout_vld || nreq >= 8) done = 1;
        end
        check({tag, " R4 dout_vld"}, dout_vld, 1);
        check({tag, " R4/R5 dout"}, dout, exp_d);
        check({tag, " R3 request count"}, nreq, exp_n);
        @(negedge clk);
        check({tag, " R4 vld one cycle"}, dout_vld, 0);
    endtask

    task automatic t_reset;
        check("R1 dout", dout, 0);
        check("R1 dout_vld", dout_vld, 0);
        check("R1 fine_req", fine_req, 0);
        check("R1 off_sel", off_sel, 0);
        check("R1 cal_avg", cal_avg, 0);
        convert(100, "R1 identity");
        convert(77, "R4 mid");
    endtask

    task automatic t_clamp;
        convert(300, "R5 high");
        convert(-5, "R5 low");
        convert(230, "R3 top offset");
    endtask

    task automatic lut_write(bit mode, int a, int d);
        @(negedge clk) begin cal_mode = mode; cal_we = 1'b1; cal_addr = 5'(a); cal_data = 5'(d); end
        @(negedge clk) begin cal_we = 1'b0; cal_mode = 1'b0; end
        if (mode) lut_m[a] = d;
    endtask

    task automatic t_lut;
        lut_write(1, 10, 20);
        convert(74, "R6 written entry");
        lut_write(0, 12, 1);
        convert(44, "R7 ignored write");
    endtask

    task automatic push(bit mode, int c);
        @(negedge clk) begin cal_mode = mode; fine_vld = 1'b1; fine_code = 5'(c); end
        @(negedge clk) begin fine_vld = 1'b0; end
    endtask

    task automatic t_avg;
        push(1, 4);  check("R8 avg 1", cal_avg, 1);
        push(1, 8);  check("R8 avg 2", cal_avg, 3);
        push(1, 12); check("R8 avg 3", cal_avg, 6);
        push(1, 16); check("R8 avg 4", cal_avg, 10);
        push(1, 0);  check("R8 window slides", cal_avg, 9);
        push(0, 31); check("R9 no update", cal_avg, 9);
        cal_mode = 1'b0;
    endtask

    task automatic t_block;
        @(negedge clk) begin cal_mode = 1'b1; start = 1'b1; end
        @(negedge clk) start = 1'b0;
        check("R10 cal blocks start", fine_req, 0);
        @(negedge clk) check("R10 cal blocks start later", fine_req, 0);
        cal_mode = 1'b0;
        // Start during a search.
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R10 busy no new req", fine_req, 0);
        check("R10 offset kept", off_sel, 0);
        fine_vld = 1'b1; fine_code = 5'd9;
        @(negedge clk) fine_vld = 1'b0;
        check("R10 result", dout, 9);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) check("R10 no restart", fine_req, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) lut_m[i] = i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clamp();
        t_lut();
        t_avg();
        t_block();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk) cyc++;
            if (cyc > 50000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end
endmodule